// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Translator

This block gives a bus master a 4 KB little-endian register window through which a message-signalled interrupt becomes a pulse on a wire. A master, typically a PCI host bridge, writes a global interrupt ID to a doorbell register. The block subtracts the first global ID of its frame, checks the result against the number of lines it drives, and pulses the matching shared-interrupt output for one clock. IDs outside the frame are dropped without trace.

The frame describes itself. A type register reports the first global ID and the line count. An interface ID register carries a product and an implementer code. A block of identification registers at the top of the window reads as zero. The base is counted in the shared-interrupt number space, so base 0 means global ID 32. Base, line count and the two codes are elaboration parameters. The register port follows APB with no wait states. A separate size input states the width of each access.

Top module: `msi_doorbell_frame`

## Requirements
- R1: After reset, every interrupt output line and the error flag are low.
- R2: A 32-bit write to offset 0x040 whose global ID G satisfies BASE+32 <= G < BASE+32+COUNT sets line G-(BASE+32), and only that line, high for exactly the one clock that follows the access phase.
- R3: Only data bits [9:0] form the global ID. Bits [31:10] do not affect which line pulses.
- R4: A doorbell write whose ID is below BASE+32, or at or above BASE+32+COUNT, pulses no line and raises no error.
- R5: The doorbell accepts a 16-bit write (psize 1, address 0x040) as well as a 32-bit write (psize 2). A byte write (psize 0) or a reserved-size write (psize 3) to the doorbell pulses nothing and raises the error flag.
- R6: A 32-bit read of offset 0x008 returns ((BASE+32) << 16) | COUNT.
- R7: A 32-bit read of offset 0xFCC returns (PRODUCT << 20) | IMPLEMENTER, with defaults 0x51 and 0x43B.
- R8: 32-bit reads of offsets 0xFD0 to 0xFFC, and of the doorbell at 0x040, return zero with no error.
- R9: A read of any other offset, or any read with psize not 2, returns zero. The error flag is then high for the one clock after the access phase.
- R10: A write to any offset other than 0x040 pulses no line and raises the error flag for one clock.
- R11: Two consecutive APB transfers to different in-range IDs give two separate pulses, in order, each one clock long.
- R12: pready is always high.
- R13: At elaboration, COUNT must lie between 1 and 128, and BASE+32+COUNT must not exceed 1020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| psize | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 reserved |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, tied high |
| irq_pulse | output | COUNT | One-clock pulses toward the interrupt controller |
| err_pulse | output | 1 | One-clock flag for an undefined offset or a bad size |

## Verification
The hardest case to reach is a pair of doorbell pulses on adjacent cycles. APB puts a setup phase between access phases, so two pulses are at least two clocks apart. The bench chains two transfers with no idle cycle between them and samples the lines after each access edge. It checks that the first pulse is gone before the second appears. Range edges are reached with a non-zero base, writing the IDs just below, at, and just above each end of the frame. Bits [15:10] are set in the 16-bit write so that the masking of the upper bits is tested on the same access.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
    localparam int MAX_LINES  = 128;
    localparam int MAX_GLOBAL = 1020;
    localparam int SPI_FIRST  = 32;

    localparam logic [11:0] OFF_TYPE     = 12'h008;
    localparam logic [11:0] OFF_DOORBELL = 12'h040;
    localparam logic [11:0] OFF_IFACE_ID = 12'hFCC;
    localparam logic [11:0] OFF_ID_LO    = 12'hFD0;
    localparam logic [11:0] OFF_ID_HI    = 12'hFFC;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/msi_access_decode.sv
module msi_access_decode
    import msi_frame_pkg::*;
#(
    parameter int BASE        = 0,
    parameter int COUNT       = 64,
    parameter int PRODUCT     = 'h51,
    parameter int IMPLEMENTER = 'h43B
) (
    input  logic        xfer,
    input  logic        is_write,
    input  logic [11:0] addr,
    input  logic [1:0]  size,
    output logic        fire,
    output logic        acc_err,
    output logic [31:0] rd_data
);
    localparam logic [31:0] TYPE_VAL  = (32'(BASE + SPI_FIRST) << 16) | 32'(COUNT);
    localparam logic [31:0] IFACE_VAL = (32'(PRODUCT) << 20) | 32'(IMPLEMENTER);

    logic aligned;
    logic rd_known;
    logic wr_size_ok;

    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        wr_size_ok = (size == SZ_WORD) || (size == SZ_HALF);
        rd_known   = aligned && ((addr == OFF_TYPE) || (addr == OFF_DOORBELL) ||
                                 (addr == OFF_IFACE_ID) ||
                                 ((addr >= OFF_ID_LO) && (addr <= OFF_ID_HI)));

        fire    = xfer && is_write && (addr == OFF_DOORBELL) && wr_size_ok;
        acc_err = 1'b0;
        rd_data = '0;

        if (xfer && is_write) begin
            acc_err = !fire;
        end else if (xfer) begin
            acc_err = !rd_known || (size != SZ_WORD);
        end

        if (!is_write && (size == SZ_WORD) && aligned) begin
            if (addr == OFF_TYPE)          rd_data = TYPE_VAL;
            else if (addr == OFF_IFACE_ID) rd_data = IFACE_VAL;
        end
    end
endmodule

// File: rtl/msi_line_select.sv
module msi_line_select
    import msi_frame_pkg::*;
#(
    parameter int BASE  = 0,
    parameter int COUNT = 64
) (
    input  logic             fire,
    input  logic [9:0]       gid,
    output logic [COUNT-1:0] hit
);
    localparam int FIRST_ID = BASE + SPI_FIRST;

    for (genvar i = 0; i < COUNT; i++) begin : g_line
        localparam logic [9:0] LINE_ID = 10'(FIRST_ID + i);
        assign hit[i] = fire && (gid == LINE_ID);
    end
endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE        = 0,
    parameter int COUNT       = 64,
    parameter int PRODUCT     = 'h51,
    parameter int IMPLEMENTER = 'h43B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [11:0]      paddr,
    input  logic [1:0]       psize,
    input  logic [31:0]      pwdata,
    output logic [31:0]      prdata,
    output logic             pready,
    output logic [COUNT-1:0] irq_pulse,
    output logic             err_pulse
);
    typedef struct packed {
        logic [COUNT-1:0] pulse;
        logic             err;
    } frame_state_t;

    frame_state_t st_d, st_q;
    logic             xfer;
    logic             fire;
    logic             acc_err;
    logic [31:0]      rd_data;
    logic [COUNT-1:0] line_hit;

    initial begin
        AST_COUNT_LIMIT: assert (COUNT >= 1 && COUNT <= MAX_LINES)
            else $error("line count %0d outside 1..%0d", COUNT, MAX_LINES); // R13
        AST_ID_CEILING: assert (BASE + SPI_FIRST + COUNT <= MAX_GLOBAL)
            else $error("frame end %0d beyond %0d", BASE + SPI_FIRST + COUNT, MAX_GLOBAL); // R13
    end

    assign xfer = psel && penable;

    msi_access_decode #(
        .BASE(BASE), .COUNT(COUNT), .PRODUCT(PRODUCT), .IMPLEMENTER(IMPLEMENTER)
    ) u_decode (
        .xfer    (xfer),
        .is_write(pwrite),
        .addr    (paddr),
        .size    (psize),
        .fire    (fire),
        .acc_err (acc_err),
        .rd_data (rd_data)
    );

    msi_line_select #(.BASE(BASE), .COUNT(COUNT)) u_select (
        .fire(fire),
        .gid (pwdata[9:0]),
        .hit (line_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = line_hit;
        st_d.err   = acc_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pulse = st_q.pulse;
    assign err_pulse = st_q.err;
    assign prdata    = rd_data;
    assign pready    = 1'b1;

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pulse)); // R2
    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pulse) |-> $past(psel && penable && pwrite)); // R2
    AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pready); // R12
    AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (irq_pulse == '0)); // R10
    AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && psize != SZ_WORD) |-> (prdata == '0)); // R9
endmodule

// File: tb/sim_msi_doorbell_frame.sv
module sim_msi_doorbell_frame;
    localparam int BASE  = 40;
    localparam int COUNT = 64;
    localparam int FIRST = BASE + 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [1:0]  psize = 2'd2;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [COUNT-1:0] irq_pulse;
    logic        err_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    msi_doorbell_frame #(.BASE(BASE), .COUNT(COUNT)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .psize(psize), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .irq_pulse(irq_pulse), .err_pulse(err_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one APB transfer; returns read data and the outputs after the access edge
    task automatic xfer(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic [COUNT-1:0] pl, output logic e);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; psize = sz; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1 rd = prdata;
        @(negedge clk);
        pl = irq_pulse; e = err_pulse;
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [COUNT-1:0] one(input int n);
        return (COUNT)'(1) << n;
    endfunction

    task automatic t_reset;
        check(irq_pulse == '0, "R1 lines", 64'(irq_pulse), 0);
        check(err_pulse == 1'b0, "R1 err", 64'(err_pulse), 0);
        check(pready == 1'b1, "R12 ready", 64'(pready), 1);
    endtask

    task automatic t_doorbell_word;
        logic [31:0] rd; logic [COUNT-1:0] pl; logic e;
        xfer(1, 12'h040, 2'd2, 32'(FIRST), rd, pl, e);
        check(pl == one(0) && !e, "R2 first line", 64'(pl), 64'(one(0)));
        @(negedge clk);
        check(irq_pulse == '0, "R2 one cycle", 64'(irq_pulse), 0);
        xfer(1, 12'h040, 2'd2, 32'(FIRST + COUNT - 1), rd, pl, e);
        check(pl == one(COUNT - 1), "R2 last line", 64'(pl), 64'(one(COUNT - 1)));
        @(negedge clk);
        xfer(1, 12'h040, 2'd2, 32'hFFFF_F400 | 32'(FIRST + 9), rd, pl, e);
        check(pl == one(9), "R3 upper bits masked", 64'(pl), 64'(one(9)));
        @(negedge clk);
    endtask

    task automatic t_out_of_range;
        logic [31:0] rd; logic [COUNT-1:0] pl; logic e;
        xfer(1, 12'h040, 2'd2, 32'(FIRST - 1), rd, pl, e);
        check(pl == '0 && !e, "R4 below base", 64'({pl, e}), 0);
        xfer(1, 12'h040, 2'd2, 32'(FIRST + COUNT), rd, pl, e);
        check(pl == '0 && !e, "R4 above top", 64'({pl, e}), 0);
        xfer(1, 12'h040, 2'd2, 32'h3FF, rd, pl, e);
        check(pl == '0 && !e, "R4 id 1023", 64'({pl, e}), 0);
        @(negedge clk);
    endtask

    task automatic t_sizes;
        logic [31:0] rd; logic [COUNT-1:0] pl; logic e;
        xfer(1, 12'h040, 2'd1, 32'h0000_FC00 | 32'(FIRST + 5), rd, pl, e);
        check(pl == one(5) && !e, "R5 halfword write", 64'(pl), 64'(one(5)));
        @(negedge clk);
        xfer(1, 12'h040, 2'd0, 32'(FIRST + 6), rd, pl, e);
        check(pl == '0 && e, "R5 byte write", 64'({pl, e}), 1);
        xfer(1, 12'h040, 2'd3, 32'(FIRST + 6), rd, pl, e);
        check(pl == '0 && e, "R5 reserved size", 64'({pl, e}), 1);
        @(negedge clk);
    endtask

    task automatic t_id_regs;
        logic [31:0] rd; logic [COUNT-1:0] pl; logic e;
        xfer(0, 12'h008, 2'd2, 0, rd, pl, e);
        check(rd == ((32'(FIRST) << 16) | 32'(COUNT)) && !e, "R6 type",
              64'(rd), 64'((32'(FIRST) << 16) | 32'(COUNT)));
        xfer(0, 12'hFCC, 2'd2, 0, rd, pl, e);
        check(rd == 32'h0510_043B && !e, "R7 iface id", 64'(rd), 64'h0510_043B);
        xfer(0, 12'hFD0, 2'd2, 0, rd, pl, e);
        check(rd == 0 && !e, "R8 id low", 64'({rd, e}), 0);
        xfer(0, 12'hFFC, 2'd2, 0, rd, pl, e);
        check(rd == 0 && !e, "R8 id high", 64'({rd, e}), 0);
        xfer(0, 12'h040, 2'd2, 0, rd, pl, e);
        check(rd == 0 && !e, "R8 doorbell reads zero", 64'({rd, e}), 0);
    endtask

    task automatic t_bad_reads;
        logic [31:0] rd; logic [COUNT-1:0] pl; logic e;
        xfer(0, 12'h100, 2'd2, 0, rd, pl, e);
        check(rd == 0 && e, "R9 undefined offset", 64'({rd, e}), 1);
        xfer(0, 12'h008, 2'd1, 0, rd, pl, e);
        check(rd == 0 && e, "R9 halfword read", 64'({rd, e}), 1);
        xfer(0, 12'hFCC, 2'd0, 0, rd, pl, e);
        check(rd == 0 && e, "R9 byte read", 64'({rd, e}), 1);
        @(negedge clk);
        check(err_pulse == 1'b0, "R9 err one cycle", 64'(err_pulse), 0);
    endtask

    task automatic t_bad_writes;
        logic [31:0] rd; logic [COUNT-1:0] pl; logic e;
        xfer(1, 12'h008, 2'd2, 32'(FIRST + 3), rd, pl, e);
        check(pl == '0 && e, "R10 write type reg", 64'({pl, e}), 1);
        xfer(1, 12'h044, 2'd2, 32'(FIRST + 3), rd, pl, e);
        check(pl == '0 && e, "R10 write near doorbell", 64'({pl, e}), 1);
        xfer(0, 12'h008, 2'd2, 0, rd, pl, e);
        check(rd == ((32'(FIRST) << 16) | 32'(COUNT)), "R10 type unchanged",
              64'(rd), 64'((32'(FIRST) << 16) | 32'(COUNT)));
        @(negedge clk);
    endtask

    task automatic t_back_to_back;
        logic [31:0] rd; logic [COUNT-1:0] pa, pb; logic e;
        xfer(1, 12'h040, 2'd2, 32'(FIRST + 12), rd, pa, e);
        xfer(1, 12'h040, 2'd2, 32'(FIRST + 13), rd, pb, e);
        check(pa == one(12), "R11 first pulse", 64'(pa), 64'(one(12)));
        check(pb == one(13), "R11 second pulse", 64'(pb), 64'(one(13)));
        @(negedge clk);
        check(irq_pulse == '0, "R11 both ended", 64'(irq_pulse), 0);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_doorbell_word();
                t_out_of_range();
                t_sizes();
                t_id_regs();
                t_bad_reads();
                t_bad_writes();
                t_back_to_back();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule